// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation-buffer miss in hardware. The caller gives it the upper 20 bits of the missing 32-bit virtual address (the page number) and the base address of the current process's first-level table. The walker then reads one word from the first-level table. If that word marks a valid second-level table, it reads one word from that second-level table. It either hands the final entry back for installation in the translation buffer or raises a page-fault (abort) indication that says which level failed.

The page number splits into two 10-bit indices, with a 12-bit offset below them. Each table level therefore holds 1024 four-byte entries. Second-level tables are present only for valid first-level entries, so an invalid first-level entry ends the walk at once and no second read is issued. Memory reads use a request/acknowledge address phase followed by a separate data-valid return. The address phase may be stretched by any number of cycles, and so may the gap before the data returns.

Top module: `pt_walk_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `req_ready` is 1 and `mem_rd_req`, `res_valid` and `fault_valid` are 0. Asserting reset in the middle of a walk abandons that walk.
- R2: The first read address is `req_root` plus 4 times the first-level index. The first-level index is bits [19:10] of `req_vpn`, which are virtual address bits [31:22].
- R3: The second read address is the first-level entry with its low 12 bits cleared, plus 4 times the second-level index. The second-level index is bits [9:0] of `req_vpn`, which are virtual address bits [21:12].
- R4: Once `mem_rd_req` is raised, it and `mem_rd_addr` stay unchanged until the cycle in which `mem_rd_ack` is high, however many cycles that takes.
- R5: Read data is taken only in a cycle with `mem_rd_valid` high, at the earliest one cycle after the acknowledge. Data presented while `mem_rd_valid` is low has no effect on the result.
- R6: A first-level entry with bit 0 equal to 0 ends the walk with a `fault_valid` pulse and `fault_level` = 0, and no second read is requested.
- R7: A second-level entry with bit 0 equal to 0 ends the walk with a `fault_valid` pulse and `fault_level` = 1.
- R8: When both entries have bit 0 equal to 1, the walk ends with a `res_valid` pulse and `res_pte` equal to the second-level entry.
- R9: `res_valid` and `fault_valid` are never high together and last exactly one cycle. `req_ready` is 1 in the following cycle. While a walk is in progress `req_ready` is 0, and a `req_valid` then does not change the walk.

Ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken when `req_ready` is 1) |
| req_ready | output | 1 | Walker idle and able to accept a walk |
| req_vpn | input | 20 | Virtual page number (virtual address bits 31:12) |
| req_root | input | 32 | First-level table base for the process |
| mem_rd_req | output | 1 | Memory read request, held until acknowledged |
| mem_rd_addr | output | 32 | Byte address of the table word to read |
| mem_rd_ack | input | 1 | Memory accepted the read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data (a table entry) |
| res_valid | output | 1 | One-cycle pulse: translation found |
| res_pte | output | 32 | Final page-table entry for installation |
| fault_valid | output | 1 | One-cycle pulse: page fault |
| fault_level | output | 1 | Failing level: 0 first, 1 second |

## Verification
Table-driven walks cover several cases: both levels valid, a first-level miss, and a second-level miss. All-zero and all-one page numbers exercise the extreme indices. A first-level entry that has high bits set but a clear valid bit shows that only bit 0 decides validity. Each walk uses a different acknowledge delay and data delay, and garbage data is driven while `mem_rd_valid` is low, so a walker that took data too early or let its address drift would show it. Directed cases add a second start request during a busy walk and a reset in the middle of a walk.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD1   = 3'd1,
      ST_WT1   = 3'd2,
      ST_RD2   = 3'd3,
      ST_WT2   = 3'd4,
      ST_DONE  = 3'd5,
      ST_FAULT = 3'd6
   } walk_st_e;

   localparam logic LVL_FIRST  = 1'b0;
   localparam logic LVL_SECOND = 1'b1;

endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr #(
   parameter int VA_W        = 32,
   parameter int OFF_W       = 12,
   parameter int L1_W        = 10,
   parameter int ENTRY_BYTES = 4,
   parameter bit BASE_ADD    = 1'b1,
   localparam int VPN_W      = VA_W - OFF_W,
   localparam int L2_W       = VPN_W - L1_W
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [VA_W-1:0]  root,
   input  logic [VPN_W-1:0] l2_base,
   input  logic             sel_l2,
   output logic [VA_W-1:0]  rd_addr
);

   localparam int ENT_SH = $clog2(ENTRY_BYTES);

   logic [L1_W-1:0] idx1;
   logic [L2_W-1:0] idx2;
   logic [VA_W-1:0] off1;
   logic [VA_W-1:0] off2;
   logic [VA_W-1:0] addr1;
   logic [VA_W-1:0] addr2;

   assign idx1 = vpn[VPN_W-1 -: L1_W];
   assign idx2 = vpn[L2_W-1:0];

   assign off1 = {{(VA_W-L1_W-ENT_SH){1'b0}}, idx1, {ENT_SH{1'b0}}};
   assign off2 = {{(VA_W-L2_W-ENT_SH){1'b0}}, idx2, {ENT_SH{1'b0}}};

   generate
      if (BASE_ADD) begin : g_root_add
         assign addr1 = root + off1;
      end else begin : g_root_cat
         assign addr1 = {root[VA_W-1:OFF_W], off1[OFF_W-1:0]};
      end
   endgenerate

   assign addr2   = {l2_base, {OFF_W{1'b0}}} + off2;
   assign rd_addr = sel_l2 ? addr2 : addr1;

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
   import pt_walk_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     rd_ack,
   input  logic     rd_valid,
   input  logic     entry_ok,
   output walk_st_e state,
   output logic     rd_req,
   output logic     take_l1,
   output logic     take_l2,
   output logic     ready,
   output logic     done,
   output logic     fault,
   output logic     fault_lvl
);

   walk_st_e nxt;
   logic     lvl_q;

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:  if (start)    nxt = ST_RD1;
         ST_RD1:   if (rd_ack)   nxt = ST_WT1;
         ST_WT1:   if (rd_valid) nxt = entry_ok ? ST_RD2 : ST_FAULT;
         ST_RD2:   if (rd_ack)   nxt = ST_WT2;
         ST_WT2:   if (rd_valid) nxt = entry_ok ? ST_DONE : ST_FAULT;
         ST_DONE:  nxt = ST_IDLE;
         ST_FAULT: nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         lvl_q <= LVL_FIRST;
      end else begin
         state <= nxt;
         if (state == ST_WT1 && rd_valid && !entry_ok) lvl_q <= LVL_FIRST;
         if (state == ST_WT2 && rd_valid && !entry_ok) lvl_q <= LVL_SECOND;
      end
   end

   assign rd_req    = (state == ST_RD1) || (state == ST_RD2);
   assign take_l1   = (state == ST_WT1) && rd_valid && entry_ok;
   assign take_l2   = (state == ST_WT2) && rd_valid;
   assign ready     = (state == ST_IDLE);
   assign done      = (state == ST_DONE);
   assign fault     = (state == ST_FAULT);
   assign fault_lvl = lvl_q;

   // R8
   wt2_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_l2 |=> (done || fault));

   // R6
   l1_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WT1 && rd_valid && !entry_ok) |=> (fault && fault_lvl == LVL_FIRST));

endmodule

// File: rtl/pt_walk_top.sv
module pt_walk_top
   import pt_walk_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int OFF_W       = 12,
   parameter int L1_W        = 10,
   parameter int ENTRY_BYTES = 4,
   parameter int VALID_BIT   = 0,
   parameter bit BASE_ADD    = 1'b1,
   localparam int VPN_W      = VA_W - OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VPN_W-1:0] req_vpn,
   input  logic [VA_W-1:0]  req_root,
   output logic             mem_rd_req,
   output logic [VA_W-1:0]  mem_rd_addr,
   input  logic             mem_rd_ack,
   input  logic             mem_rd_valid,
   input  logic [VA_W-1:0]  mem_rd_data,
   output logic             res_valid,
   output logic [VA_W-1:0]  res_pte,
   output logic             fault_valid,
   output logic             fault_level
);

   localparam int L2_W = VPN_W - L1_W;

   initial begin
      if (L1_W < 1 || L2_W < 1)
         $fatal(1, "pt_walk_top: both index fields need at least one bit");
      if (ENTRY_BYTES != 4 && ENTRY_BYTES != 8)
         $fatal(1, "pt_walk_top: entry size must be 4 or 8 bytes");
      if (L2_W + $clog2(ENTRY_BYTES) > OFF_W)
         $fatal(1, "pt_walk_top: a second-level table must fit in one page");
      if (!BASE_ADD && (L1_W + $clog2(ENTRY_BYTES) > OFF_W))
         $fatal(1, "pt_walk_top: concatenated root needs the first table within one page");
      if (VALID_BIT < 0 || VALID_BIT >= OFF_W)
         $fatal(1, "pt_walk_top: valid bit must lie below the frame field");
   end

   walk_st_e         state;
   logic             start;
   logic             take_l1;
   logic             take_l2;
   logic             done;
   logic             fault;
   logic             flvl;
   logic [VPN_W-1:0] vpn_q;
   logic [VA_W-1:0]  root_q;
   logic [VPN_W-1:0] l1_q;
   logic [VA_W-1:0]  pte_q;

   assign start = req_valid && req_ready;

   pt_walk_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .rd_ack    (mem_rd_ack),
      .rd_valid  (mem_rd_valid),
      .entry_ok  (mem_rd_data[VALID_BIT]),
      .state     (state),
      .rd_req    (mem_rd_req),
      .take_l1   (take_l1),
      .take_l2   (take_l2),
      .ready     (req_ready),
      .done      (done),
      .fault     (fault),
      .fault_lvl (flvl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vpn_q  <= '0;
         root_q <= '0;
         l1_q   <= '0;
         pte_q  <= '0;
      end else begin
         if (start) begin
            vpn_q  <= req_vpn;
            root_q <= req_root;
         end
         if (take_l1) l1_q  <= mem_rd_data[VA_W-1:OFF_W];
         if (take_l2) pte_q <= mem_rd_data;
      end
   end

   pt_walk_addr #(
      .VA_W        (VA_W),
      .OFF_W       (OFF_W),
      .L1_W        (L1_W),
      .ENTRY_BYTES (ENTRY_BYTES),
      .BASE_ADD    (BASE_ADD)
   ) u_addr (
      .vpn     (vpn_q),
      .root    (root_q),
      .l2_base (l1_q),
      .sel_l2  (state == ST_RD2),
      .rd_addr (mem_rd_addr)
   );

   assign res_valid   = done;
   assign res_pte     = pte_q;
   assign fault_valid = fault;
   assign fault_level = flvl;

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

   // R9
   end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid && fault_valid));

   // R9
   end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid || fault_valid) |=> (!res_valid && !fault_valid && req_ready));

   // R6
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> !mem_rd_req);

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && req_valid) |=> $stable(vpn_q));

endmodule

// File: tb/pt_walk_top_tb.sv
module pt_walk_top_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [19:0] req_vpn;
   logic [31:0] req_root;
   logic        mem_rd_req;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_ack;
   logic        mem_rd_valid;
   logic [31:0] mem_rd_data;
   logic        res_valid;
   logic [31:0] res_pte;
   logic        fault_valid;
   logic        fault_level;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   pt_walk_top u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_vpn      (req_vpn),
      .req_root     (req_root),
      .mem_rd_req   (mem_rd_req),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_ack   (mem_rd_ack),
      .mem_rd_valid (mem_rd_valid),
      .mem_rd_data  (mem_rd_data),
      .res_valid    (res_valid),
      .res_pte      (res_pte),
      .fault_valid  (fault_valid),
      .fault_level  (fault_level)
   );

   // kind: 0 translation, 1 first-level fault, 2 second-level fault
   typedef struct packed {
      logic [31:0] va;
      logic [31:0] root;
      logic [31:0] l1;
      logic [31:0] l2;
      logic [3:0]  ack_dly;
      logic [3:0]  dat_dly;
      logic [1:0]  kind;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{32'h0040_3ABC, 32'h0010_0000, 32'h0020_0001, 32'h1234_5007, 4'd0, 4'd0, 2'd0},
      '{32'hFFFF_FFFF, 32'h0000_8000, 32'hABCD_E001, 32'hFEDC_B003, 4'd3, 4'd2, 2'd0},
      '{32'h0000_0000, 32'h0003_0000, 32'hFFFF_F000, 32'h0000_0001, 4'd1, 4'd0, 2'd1},
      '{32'h8020_1000, 32'h0000_4000, 32'h0055_5001, 32'h9999_9000, 4'd0, 4'd4, 2'd2},
      '{32'h1234_5678, 32'h0ABC_0000, 32'h7777_7FFF, 32'h0000_0001, 4'd2, 4'd1, 2'd0},
      '{32'h7FC0_0FFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 4'd5, 4'd5, 2'd1}
   };

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   function automatic logic [31:0] l1_addr(input vec_t v);
      return v.root + {20'd0, v.va[31:22], 2'b00};
   endfunction

   function automatic logic [31:0] l2_addr(input vec_t v);
      return {v.l1[31:12], 12'h000} + {20'd0, v.va[21:12], 2'b00};
   endfunction

   // answer one read: check address, hold, ack, delay with garbage, data
   task automatic serve(input logic [31:0] exp_addr, input logic [31:0] data,
                        input int ackd, input int datd, input string rq);
      int n = 0;
      logic hold_ok = 1'b1;
      while (!mem_rd_req && n < 50) begin
         @(negedge clk);
         n++;
      end
      chk("R4", "read request seen", {31'd0, mem_rd_req}, 32'd1);
      chk(rq, "read address", mem_rd_addr, exp_addr);
      for (int k = 0; k < ackd; k++) begin
         @(negedge clk);
         if (!mem_rd_req || mem_rd_addr !== exp_addr) hold_ok = 1'b0;
      end
      chk("R4", "request held until ack", {31'd0, hold_ok}, 32'd1);
      mem_rd_ack  = 1'b1;
      mem_rd_data = ~data;
      @(negedge clk);
      mem_rd_ack = 1'b0;
      for (int k = 0; k < datd; k++) begin
         mem_rd_data = ~data ^ k;
         @(negedge clk);
      end
      mem_rd_valid = 1'b1;
      mem_rd_data  = data;
      @(negedge clk);
      mem_rd_valid = 1'b0;
      mem_rd_data  = ~data;
   endtask

   task automatic await_end(input logic [1:0] kind, input logic [31:0] exp_pte,
                            input string rq);
      int   n = 0;
      logic extra_req = 1'b0;
      while (!res_valid && !fault_valid && n < 20) begin
         if (mem_rd_req) extra_req = 1'b1;
         @(negedge clk);
         n++;
      end
      if (kind == 2'd0) begin
         chk(rq, "res_valid", {31'd0, res_valid}, 32'd1);
         chk(rq, "fault_valid", {31'd0, fault_valid}, 32'd0);
         chk(rq, "res_pte", res_pte, exp_pte);
      end else begin
         chk(rq, "fault_valid", {31'd0, fault_valid}, 32'd1);
         chk(rq, "res_valid", {31'd0, res_valid}, 32'd0);
         chk(rq, "fault_level", {31'd0, fault_level}, (kind == 2'd1) ? 32'd0 : 32'd1);
         if (kind == 2'd1)
            chk("R6", "no second read", {31'd0, extra_req | mem_rd_req}, 32'd0);
      end
      @(negedge clk);
      chk("R9", "pulse ended", {30'd0, res_valid, fault_valid}, 32'd0);
      chk("R9", "ready again", {31'd0, req_ready}, 32'd1);
   endtask

   task automatic start_walk(input vec_t v);
      chk("R9", "ready before start", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1;
      req_vpn   = v.va[31:12];
      req_root  = v.root;
      @(negedge clk);
      req_valid = 1'b0;
      req_vpn   = '0;
      req_root  = '0;
   endtask

   task automatic run_vec(input vec_t v);
      start_walk(v);
      serve(l1_addr(v), v.l1, int'(v.ack_dly), int'(v.dat_dly), "R2");
      if (v.kind != 2'd1)
         serve(l2_addr(v), v.l2, int'(v.ack_dly), int'(v.dat_dly), "R3");
      await_end(v.kind, v.l2, (v.kind == 2'd0) ? "R8" : (v.kind == 2'd1) ? "R6" : "R7");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n        = 1'b0;
      req_valid    = 1'b0;
      req_vpn      = '0;
      req_root     = '0;
      mem_rd_ack   = 1'b0;
      mem_rd_valid = 1'b0;
      mem_rd_data  = '0;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1", "ready in reset", {31'd0, req_ready}, 32'd1);
      chk("R1", "outputs quiet in reset",
          {29'd0, mem_rd_req, res_valid, fault_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ready after reset", {31'd0, req_ready}, 32'd1);
      chk("R1", "outputs quiet after reset",
          {29'd0, mem_rd_req, res_valid, fault_valid}, 32'd0);

      // table of walks: R2 R3 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R9: start request while busy is ignored
      start_walk(VECS[0]);
      chk("R9", "busy not ready", {31'd0, req_ready}, 32'd0);
      req_valid = 1'b1;
      req_vpn   = 20'hFFFFF;
      req_root  = 32'h0F00_0000;
      @(negedge clk);
      req_valid = 1'b0;
      serve(l1_addr(VECS[0]), VECS[0].l1, 1, 1, "R9");
      serve(l2_addr(VECS[0]), VECS[0].l2, 0, 2, "R9");
      await_end(2'd0, VECS[0].l2, "R9");

      // R1: reset in the middle of a walk
      start_walk(VECS[1]);
      mem_rd_ack = 1'b1;
      @(negedge clk);
      mem_rd_ack = 1'b0;
      rst_n      = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1", "walk abandoned by reset", {30'd0, req_ready, mem_rd_req}, 32'd2);
      @(negedge clk);
      chk("R1", "idle after mid-walk reset",
          {28'd0, req_ready, mem_rd_req, res_valid, fault_valid}, 32'd8);

      // R5: a fresh walk after the reset still works
      run_vec(VECS[4]);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule